// File: doc/BRIEF.md
# Third-Order Cascaded Delta-Sigma Modulus Controller

This block produces the division-modulus offset for a fractional-N divider. Every enabled reference clock edge it takes an unsigned fractional word `frac_word` of `W` bits and emits a two-bit signed offset. Logic outside the block adds that offset to the integer divide ratio. Averaged over time, the offset equals `frac_word / 2^W`. The quantization noise it adds is shaped by `(1 - z^-1)^3`.

Two stages do the work. The first is a plain `W`-bit accumulator. Its carry is the coarse output, and its wrapped sum is the residual error. The second stage is a double-integrator loop with a one-bit quantizer, and it shapes that residual with a second-order response. Its signal path has a latency of two cycles. A cancellation network adds the first-stage carry, delayed by two cycles, to the first difference of the second-stage bit. This removes the first-stage error and leaves an offset in the range -1..+2.

Words above three quarters of full scale lie outside the range the block guarantees. Such a word is replaced by that limit, and a sticky flag records that it happened.

Top module: `mash12_modctl`

## Requirements
- R1: A clock edge with `rst_n` low clears all internal state, sets `mod_off` to 2'b11 (offset 0) and clears `overrange`.
- R2: `mod_off` carries the offset y as y-1 in two's complement: 2'b10 means -1, 2'b11 means 0, 2'b00 means +1 and 2'b01 means +2.
- R3: With a constant word k held from reset, the offsets produced on the first M*2^W+2 enabled edges sum to M*k or M*k+1.
- R4: With a word of zero from reset, every offset is 0.
- R5: An enabled edge that samples a word above 3*2^(W-2) uses 3*2^(W-2) in its place and sets `overrange`. The flag then stays set until reset, even after smaller words follow.
- R6: While `en` is low, no state changes. `mod_off` and `overrange` hold their values, and words presented during that time have no effect, including words above the limit.
- R7: A word exactly equal to 3*2^(W-2) is used unchanged and does not set `overrange`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Clock enable; when low, all state is frozen |
| frac_word | input | W | Unsigned fractional word, sampled on enabled edges |
| mod_off | output | 2 | Modulus offset y stored as y-1: 10=-1, 11=0, 00=+1, 01=+2 |
| overrange | output | 1 | Sticky flag: a word above 3/4 of full scale has been sampled |

## Verification
The embedded properties assume that `rst_n` and `en` are driven to known levels from the first edge on, and that `frac_word` is free of X and Z on every enabled edge. The stimulus changes its inputs only at a fixed offset after the rising edge and holds them steady through the next edge. It asserts reset first, then holds each word constant for whole windows of 2^W+2 enabled edges, so that the sum of the offsets can be predicted exactly. The word is changed only inside intervals where `en` is low, to show that such changes are ignored.

// File: rtl/mash12_modctl.sv
module mash12_modctl #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] frac_word,
  output logic [1:0]   mod_off,
  output logic         overrange
);
  localparam int CW = W + 6;
  localparam logic [W-1:0] LIMIT = {2'b11, {(W-2){1'b0}}};
  localparam logic signed [CW-1:0] FULL = CW'(1) <<< W;
  localparam logic signed [CW-1:0] HALF = CW'(1) <<< (W-1);
  localparam logic signed [CW-1:0] SATP = (CW'(1) <<< (W+2)) - CW'(1);
  localparam logic signed [CW-1:0] SATN = -(CW'(1) <<< (W+2));

  function automatic logic signed [CW-1:0] clip(input logic signed [CW-1:0] v);
    return (v > SATP) ? SATP : (v < SATN) ? SATN : v;
  endfunction

  logic [W-1:0] word_in, acc1, e1;
  logic [W:0]   s1;
  logic         c1, c2, c2_prev, over_now;
  logic [1:0]   c1_dly;
  logic signed [CW-1:0] int1, int2, fb, nxt1, nxt2;
  logic signed [2:0]    y_next;

  assign over_now = frac_word > LIMIT;
  assign word_in  = over_now ? LIMIT : frac_word;
  assign s1       = {1'b0, acc1} + {1'b0, word_in};
  assign c1       = s1[W];
  assign e1       = s1[W-1:0];

  assign c2   = int2 >= HALF;
  assign fb   = c2 ? FULL : '0;
  assign nxt1 = int1 + CW'(e1) - fb;
  assign nxt2 = int2 + int1 - (fb <<< 1);

  assign y_next = 3'(c1_dly[1]) + 3'(c2) - 3'(c2_prev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc1      <= '0;
      int1      <= '0;
      int2      <= '0;
      c1_dly    <= '0;
      c2_prev   <= 1'b0;
      mod_off   <= 2'b11;
      overrange <= 1'b0;
    end else if (en) begin
      acc1      <= e1;
      int1      <= clip(nxt1);
      int2      <= clip(nxt2);
      c1_dly    <= {c1_dly[0], c1};
      c2_prev   <= c2;
      mod_off   <= 2'(y_next - 3'sd1);
      overrange <= overrange | over_now;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (mod_off == 2'b11 && !overrange));

  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(mod_off) && $stable(overrange)));

  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frac_word > LIMIT) |=> overrange);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrange |=> overrange);

  a_r7_no_flag_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (!overrange && en && frac_word <= LIMIT) |=> !overrange);
endmodule

// File: tb/mash12_modctl_test.sv
module mash12_modctl_test;
  localparam int W = 8;
  localparam int WIN = (1 << W) + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [W-1:0] frac_word = '0;
  logic [1:0] mod_off;
  logic overrange;
  int checks = 0;
  int errors = 0;
  int acc_sum;

  mash12_modctl #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .frac_word(frac_word),
    .mod_off(mod_off), .overrange(overrange)
  );

  always #4 clk = ~clk;

  function automatic int dec(input logic [1:0] c);
    return int'($signed(c)) + 1;
  endfunction

  task automatic check(input string req, input int act, input int exp_lo, input int exp_hi);
    checks++;
    if (act < exp_lo || act > exp_hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, exp_lo, exp_hi);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    en = 1'b1;
    frac_word = 8'd77;
    step();
    step();
    rst_n = 1'b1;
    acc_sum = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      acc_sum += dec(mod_off);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset code", int'(mod_off), 3, 3);
    check("R1 reset flag", int'(overrange), 0, 0);
    check("R2 zero offset code", dec(mod_off), 0, 0);
  endtask

  task automatic t_average(input int k, input int m);
    do_reset();
    frac_word = W'(k);
    run(m * (1 << W) + 2);
    check($sformatf("R3 sum k=%0d m=%0d", k, m), acc_sum, m * k, m * k + 1);
    check($sformatf("R2 decoded sum k=%0d", k), acc_sum, m * k, m * k + 1);
  endtask

  task automatic t_zero();
    int bad;
    bad = 0;
    do_reset();
    frac_word = '0;
    for (int i = 0; i < 300; i++) begin
      step();
      if (dec(mod_off) != 0) bad++;
    end
    check("R4 zero word nonzero offsets", bad, 0, 0);
  endtask

  task automatic t_clamp();
    do_reset();
    frac_word = 8'd255;
    run(WIN);
    check("R5 clamped sum", acc_sum, 192, 193);
    check("R5 flag set", int'(overrange), 1, 1);
    frac_word = 8'd10;
    run(40);
    check("R5 flag sticky", int'(overrange), 1, 1);
  endtask

  task automatic t_limit();
    do_reset();
    frac_word = 8'd192;
    run(WIN);
    check("R7 sum at limit", acc_sum, 192, 193);
    check("R7 no flag at limit", int'(overrange), 0, 0);
  endtask

  task automatic t_enable();
    logic [1:0] held;
    int moved;
    do_reset();
    frac_word = 8'd100;
    run(100);
    held = mod_off;
    moved = 0;
    en = 1'b0;
    frac_word = 8'd250;
    for (int i = 0; i < 20; i++) begin
      step();
      if (mod_off != held) moved++;
    end
    check("R6 output held", moved, 0, 0);
    check("R6 word ignored, no flag", int'(overrange), 0, 0);
    en = 1'b1;
    frac_word = 8'd100;
    run(WIN - 100);
    check("R6 sum unaffected by pause", acc_sum, 100, 101);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_average(1, 1);
    t_average(37, 1);
    t_average(128, 2);
    t_average(171, 1);
    t_zero();
    t_clamp();
    t_limit();
    t_enable();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule